// File: doc/BRIEF.md
# PCI Target Window Decoder and Configuration Gate

This block sits at the PCI target edge of a bridge. Each incoming memory cycle address is compared against two base address windows. When an address falls inside an enabled window, the block returns the local bus address. That address is the window's local translation base plus the offset of the address inside the window. The same block holds the PCI configuration header registers and the local-only window registers. It decides whether a configuration access from the PCI side is served or answered with retry, and which registers that side may change.

Firmware on the local side programs the registers through a write port. It sets up the identity values, the window sizes and the translation bases, then sets the host configuration enable. After that, PCI enumeration software can size and place the windows through the base address registers. Memory decode begins only once the memory enable bit of the command register is set.

All decode and read outputs are combinational. Writes from either side take effect at the next rising clock edge.

Top module: `pci_tgt_window`

## Requirements
- R1: After reset, the command register, the base address registers, the translation bases, the size masks, the window 2 enable and the host configuration enable are all 0.
- R2: While the host configuration enable is 0, every configuration access raises `cfg_retry_o`, returns read data 0 and changes no register. The host configuration enable is bit 0 of config dword index 24.
- R3: While the memory enable is 0, every memory cycle gives `mem_hit_o`=0 and `mem_ignore_o`=1. The memory enable is command register bit 1, in config dword index 1, bits 15:0.
- R4: A memory cycle that hits window w returns `mem_laddr_o` = lbase[w] + (addr & mask[w]), with `mem_win_o`=w.
- R5: Window 0 is always enabled. Window 1 hits only while bit 0 of local bank index 68 is 1.
- R6: When an address falls in both windows, window 0 is reported.
- R7: A window whose size mask is 0 never hits, and its base address register reads as 0.
- R8: A size mask holds ones in its offset bits. Base address register bits under the mask read as 0. BAR w sits at config dword index 4+w and is writable from the PCI side.
- R9: The identity dword (index 0), the class dword (index 2), the subsystem dword (index 11) and the options dword (index 24) are writable only from the local side. PCI-side writes to them have no effect.
- R10: Indices 64 and above are the local bank. It holds lbase[w] at 64+2w, mask[w] at 65+2w and the window 2 enable at 68. PCI-side reads of the bank return 0 and PCI-side writes to it are ignored.
- R11: Unoccupied config indices read as 0 from the PCI side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lcl_we_i | input | 1 | Local-side register write strobe |
| lcl_idx_i | input | 7 | Local-side register index (bit 6 selects the local bank) |
| lcl_wdata_i | input | 32 | Local-side write data |
| cfg_valid_i | input | 1 | PCI configuration access present |
| cfg_we_i | input | 1 | PCI configuration access is a write |
| cfg_idx_i | input | 7 | PCI configuration dword index |
| cfg_wdata_i | input | 32 | PCI configuration write data |
| cfg_retry_o | output | 1 | Configuration access must be retried |
| cfg_rdata_o | output | 32 | Configuration read data |
| mem_valid_i | input | 1 | PCI memory cycle address present |
| mem_addr_i | input | 32 | PCI memory cycle address |
| mem_hit_o | output | 1 | Address claimed by a window |
| mem_win_o | output | 1 | Index of the claiming window |
| mem_laddr_o | output | 32 | Translated local bus address |
| mem_ignore_o | output | 1 | Cycle not claimed (master abort) |

## Verification
The assertions assume that a size mask is a contiguous run of ones from bit 0. They also assume that no agent other than the two write ports changes register state. The stimulus follows this by programming only masks of the form 2^k-1. The stimulus issues configuration and memory accesses one at a time, each with its inputs held steady between clock edges. Where a local write and a PCI write target the same register, the local write takes precedence. The bench never issues both in the same cycle.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  parameter int AW     = 32;
  parameter int WIN_N  = 2;
  parameter int IDX_W  = 7;
  localparam int WSEL_W = (WIN_N > 1) ? $clog2(WIN_N) : 1;

  localparam logic [IDX_W-1:0] IX_IDENT  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_CMD    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_CLASS  = IDX_W'(2);
  localparam int               IX_BAR0   = 4;
  localparam logic [IDX_W-1:0] IX_SUBSYS = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_OPT    = IDX_W'(24);
  localparam int               IX_BANK   = 64;
  localparam logic [IDX_W-1:0] IX_W2EN   = IDX_W'(IX_BANK + 2*WIN_N);

  typedef struct packed {
    logic [31:0]                ident;
    logic [31:0]                class_rev;
    logic [31:0]                subsys;
    logic [15:0]                cmd;
    logic                       host_en;
    logic                       win2_en;
    logic [WIN_N-1:0][AW-1:0]   bar;
    logic [WIN_N-1:0][AW-1:0]   lbase;
    logic [WIN_N-1:0][AW-1:0]   mask;
  } regs_t;

  // visible BAR value: zero when the window has no size
  function automatic logic [AW-1:0] bar_view(input logic [AW-1:0] bar,
                                             input logic [AW-1:0] mask);
    return (mask == '0) ? '0 : (bar & ~mask);
  endfunction
endpackage

// File: rtl/pci_tgt_regs.sv
module pci_tgt_regs
  import pci_tgt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lcl_we_i,
  input  logic [IDX_W-1:0] lcl_idx_i,
  input  logic [31:0]      lcl_wdata_i,
  input  logic             pci_we_i,
  input  logic [IDX_W-1:0] pci_idx_i,
  input  logic [31:0]      pci_wdata_i,
  output regs_t            regs_o
);
  regs_t r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '0;
    end else if (lcl_we_i) begin
      if (lcl_idx_i == IX_IDENT)  r_q.ident     <= lcl_wdata_i;
      if (lcl_idx_i == IX_CMD)    r_q.cmd       <= lcl_wdata_i[15:0];
      if (lcl_idx_i == IX_CLASS)  r_q.class_rev <= lcl_wdata_i;
      if (lcl_idx_i == IX_SUBSYS) r_q.subsys    <= lcl_wdata_i;
      if (lcl_idx_i == IX_OPT)    r_q.host_en   <= lcl_wdata_i[0];
      if (lcl_idx_i == IX_W2EN)   r_q.win2_en   <= lcl_wdata_i[0];
      for (int w = 0; w < WIN_N; w++) begin
        if (lcl_idx_i == IDX_W'(IX_BAR0 + w))
          r_q.bar[w] <= lcl_wdata_i & ~r_q.mask[w];
        if (lcl_idx_i == IDX_W'(IX_BANK + 2*w))
          r_q.lbase[w] <= lcl_wdata_i;
        if (lcl_idx_i == IDX_W'(IX_BANK + 2*w + 1))
          r_q.mask[w] <= lcl_wdata_i;
      end
    end else if (pci_we_i) begin
      // PCI side may change only command and BARs
      if (pci_idx_i == IX_CMD) r_q.cmd <= pci_wdata_i[15:0];
      for (int w = 0; w < WIN_N; w++) begin
        if (pci_idx_i == IDX_W'(IX_BAR0 + w))
          r_q.bar[w] <= pci_wdata_i & ~r_q.mask[w];
      end
    end
  end

  assign regs_o = r_q;
endmodule

// File: rtl/pci_tgt_cfg_gate.sv
module pci_tgt_cfg_gate
  import pci_tgt_pkg::*;
(
  input  logic             cfg_valid_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  regs_t            regs_i,
  output logic             cfg_retry_o,
  output logic             pci_we_o,
  output logic [31:0]      cfg_rdata_o
);
  logic [31:0] view;

  assign cfg_retry_o = cfg_valid_i & ~regs_i.host_en;
  assign pci_we_o    = cfg_valid_i & cfg_we_i & regs_i.host_en;

  always_comb begin
    view = '0;
    if (cfg_idx_i == IX_IDENT)  view = regs_i.ident;
    if (cfg_idx_i == IX_CMD)    view = {16'h0, regs_i.cmd};
    if (cfg_idx_i == IX_CLASS)  view = regs_i.class_rev;
    if (cfg_idx_i == IX_SUBSYS) view = regs_i.subsys;
    if (cfg_idx_i == IX_OPT)    view = {31'h0, regs_i.host_en};
    for (int w = 0; w < WIN_N; w++) begin
      if (cfg_idx_i == IDX_W'(IX_BAR0 + w))
        view = bar_view(regs_i.bar[w], regs_i.mask[w]);
    end
  end

  assign cfg_rdata_o = (cfg_valid_i & ~cfg_we_i & regs_i.host_en) ? view : '0;
endmodule

// File: rtl/pci_tgt_win_dec.sv
module pci_tgt_win_dec
  import pci_tgt_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] bar_i,
  input  logic [AW-1:0] mask_i,
  input  logic          en_i,
  output logic          hit_o,
  output logic [AW-1:0] off_o
);
  assign hit_o = en_i && (mask_i != '0) && ((addr_i & ~mask_i) == (bar_i & ~mask_i));
  assign off_o = addr_i & mask_i;
endmodule

// File: rtl/pci_tgt_window.sv
module pci_tgt_window
  import pci_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lcl_we_i,
  input  logic [IDX_W-1:0]  lcl_idx_i,
  input  logic [31:0]       lcl_wdata_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic              cfg_retry_o,
  output logic [31:0]       cfg_rdata_o,
  input  logic              mem_valid_i,
  input  logic [AW-1:0]     mem_addr_i,
  output logic              mem_hit_o,
  output logic [WSEL_W-1:0] mem_win_o,
  output logic [AW-1:0]     mem_laddr_o,
  output logic              mem_ignore_o
);
  regs_t                    regs;
  logic                     pci_we;
  logic [WIN_N-1:0]         win_hit;
  logic [WIN_N-1:0]         win_en;
  logic [WIN_N-1:0][AW-1:0] win_off;
  logic [WSEL_W-1:0]        sel;
  logic                     any_hit;

  pci_tgt_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lcl_we_i    (lcl_we_i),
    .lcl_idx_i   (lcl_idx_i),
    .lcl_wdata_i (lcl_wdata_i),
    .pci_we_i    (pci_we),
    .pci_idx_i   (cfg_idx_i),
    .pci_wdata_i (cfg_wdata_i),
    .regs_o      (regs)
  );

  pci_tgt_cfg_gate u_gate (
    .cfg_valid_i (cfg_valid_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .regs_i      (regs),
    .cfg_retry_o (cfg_retry_o),
    .pci_we_o    (pci_we),
    .cfg_rdata_o (cfg_rdata_o)
  );

  for (genvar w = 0; w < WIN_N; w++) begin : g_win
    if (w == 0) begin : g_fixed
      assign win_en[w] = 1'b1;
    end else begin : g_prog
      assign win_en[w] = regs.win2_en;
    end
    pci_tgt_win_dec u_dec (
      .addr_i (mem_addr_i),
      .bar_i  (regs.bar[w]),
      .mask_i (regs.mask[w]),
      .en_i   (win_en[w]),
      .hit_o  (win_hit[w]),
      .off_o  (win_off[w])
    );
  end

  // lowest index wins
  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int w = WIN_N-1; w >= 0; w--) begin
      if (win_hit[w]) begin
        sel     = WSEL_W'(w);
        any_hit = 1'b1;
      end
    end
  end

  assign mem_hit_o    = mem_valid_i & regs.cmd[1] & any_hit;
  assign mem_win_o    = mem_hit_o ? sel : '0;
  assign mem_laddr_o  = mem_hit_o ? (regs.lbase[sel] + win_off[sel]) : '0;
  assign mem_ignore_o = mem_valid_i & ~mem_hit_o;
endmodule

// File: rtl/pci_tgt_window_chk.sv
module pci_tgt_window_chk
  import pci_tgt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lcl_we_i,
  input logic              cfg_valid_i,
  input logic              cfg_retry_o,
  input logic              mem_valid_i,
  input logic              mem_hit_o,
  input logic [WSEL_W-1:0] mem_win_o,
  input logic              mem_ignore_o,
  input regs_t             regs
);
  assert_cfg_retry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && !regs.host_en |-> cfg_retry_o);

  assert_retry_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_retry_o && !lcl_we_i |=> $stable(regs.cmd) && $stable(regs.bar));

  assert_mem_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && !regs.cmd[1] |-> mem_ignore_o && !mem_hit_o);

  assert_hit_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hit_o |-> mem_valid_i && !mem_ignore_o);

  assert_win2_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hit_o && (mem_win_o != '0) |-> regs.win2_en);

  assert_size0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hit_o && (mem_win_o == '0) |-> regs.mask[0] != '0);

  assert_ident_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcl_we_i |=> $stable(regs.ident) && $stable(regs.class_rev) &&
                  $stable(regs.subsys) && $stable(regs.host_en));

  assert_bank_ro_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcl_we_i |=> $stable(regs.lbase) && $stable(regs.mask) && $stable(regs.win2_en));
endmodule

bind pci_tgt_window pci_tgt_window_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lcl_we_i     (lcl_we_i),
  .cfg_valid_i  (cfg_valid_i),
  .cfg_retry_o  (cfg_retry_o),
  .mem_valid_i  (mem_valid_i),
  .mem_hit_o    (mem_hit_o),
  .mem_win_o    (mem_win_o),
  .mem_ignore_o (mem_ignore_o),
  .regs         (regs)
);

// File: tb/pci_tgt_window_test.sv
module pci_tgt_window_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lcl_we_i = 1'b0;
  logic [6:0]  lcl_idx_i = '0;
  logic [31:0] lcl_wdata_i = '0;
  logic        cfg_valid_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        cfg_retry_o;
  logic [31:0] cfg_rdata_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_addr_i = '0;
  logic        mem_hit_o;
  logic [0:0]  mem_win_o;
  logic [31:0] mem_laddr_o;
  logic        mem_ignore_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_tgt_window uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lcl_we_i(lcl_we_i), .lcl_idx_i(lcl_idx_i), .lcl_wdata_i(lcl_wdata_i),
    .cfg_valid_i(cfg_valid_i), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_retry_o(cfg_retry_o), .cfg_rdata_o(cfg_rdata_o),
    .mem_valid_i(mem_valid_i), .mem_addr_i(mem_addr_i), .mem_hit_o(mem_hit_o),
    .mem_win_o(mem_win_o), .mem_laddr_o(mem_laddr_o), .mem_ignore_o(mem_ignore_o)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic        win;
    logic [31:0] laddr;
  } vec_t;

  // win0: bar 0x8010_0000 mask 0x000F_FFFF lbase 0x1000_0000
  // win1: bar 0x9000_0000 mask 0x0000_FFFF lbase 0x2000_0000
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h8010_0000, 1'b1, 1'b0, 32'h1000_0000},
    '{32'h801F_FFFF, 1'b1, 1'b0, 32'h100F_FFFF},
    '{32'h8020_0000, 1'b0, 1'b0, 32'h0000_0000},
    '{32'h9000_1234, 1'b1, 1'b1, 32'h2000_1234},
    '{32'h9001_0000, 1'b0, 1'b0, 32'h0000_0000},
    '{32'h800F_FFFF, 1'b0, 1'b0, 32'h0000_0000},
    '{32'h9000_FFFF, 1'b1, 1'b1, 32'h2000_FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic lcl_wr(input logic [6:0] idx, input logic [31:0] d);
    @(negedge clk);
    lcl_we_i = 1'b1; lcl_idx_i = idx; lcl_wdata_i = d;
    @(negedge clk);
    lcl_we_i = 1'b0;
  endtask

  task automatic cfg_acc(input logic we, input logic [6:0] idx, input logic [31:0] d,
                         output logic [31:0] rd, output logic rt);
    @(negedge clk);
    cfg_valid_i = 1'b1; cfg_we_i = we; cfg_idx_i = idx; cfg_wdata_i = d;
    #1;
    rd = cfg_rdata_o; rt = cfg_retry_o;
    @(negedge clk);
    cfg_valid_i = 1'b0; cfg_we_i = 1'b0;
  endtask

  task automatic mem_probe(input logic [31:0] a, output logic h, output logic w,
                           output logic [31:0] la, output logic ig);
    @(negedge clk);
    mem_valid_i = 1'b1; mem_addr_i = a;
    #1;
    h = mem_hit_o; w = mem_win_o; la = mem_laddr_o; ig = mem_ignore_o;
    mem_valid_i = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, la;
    logic rt, h, w, ig;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1/R2: reset state, retry on any config access
    cfg_acc(1'b0, 7'd0, '0, rd, rt);
    chk("R1 retry at reset", {31'h0, rt}, 32'h1);
    chk("R2 retry read data", rd, 32'h0);
    mem_probe(32'h0000_0000, h, w, la, ig);
    chk("R1 no hit at reset", {31'h0, h}, 32'h0);
    chk("R3 ignore at reset", {31'h0, ig}, 32'h1);

    // R2: PCI write during retry must not land
    cfg_acc(1'b1, 7'd1, 32'h0000_0002, rd, rt);
    chk("R2 retry on write", {31'h0, rt}, 32'h1);

    lcl_wr(7'd0,  32'h1234_ABCD);
    lcl_wr(7'd2,  32'h0680_0001);
    lcl_wr(7'd11, 32'h5678_9ABC);
    lcl_wr(7'd64, 32'h1000_0000);
    lcl_wr(7'd24, 32'h1);

    cfg_acc(1'b0, 7'd1, '0, rd, rt);
    chk("R2 no retry when enabled", {31'h0, rt}, 32'h0);
    chk("R2 retried write ignored", rd, 32'h0);
    cfg_acc(1'b0, 7'd4, '0, rd, rt);
    chk("R7 BAR of size-0 window", rd, 32'h0);

    // R9: identity read-only from PCI
    cfg_acc(1'b0, 7'd0, '0, rd, rt);
    chk("R9 ident read", rd, 32'h1234_ABCD);
    cfg_acc(1'b1, 7'd0, 32'hFFFF_FFFF, rd, rt);
    cfg_acc(1'b0, 7'd0, '0, rd, rt);
    chk("R9 ident unchanged", rd, 32'h1234_ABCD);
    cfg_acc(1'b1, 7'd11, 32'h0, rd, rt);
    cfg_acc(1'b0, 7'd11, '0, rd, rt);
    chk("R9 subsys unchanged", rd, 32'h5678_9ABC);
    cfg_acc(1'b1, 7'd24, 32'h0, rd, rt);
    cfg_acc(1'b0, 7'd24, '0, rd, rt);
    chk("R9 options unchanged", rd, 32'h1);
    chk("R9 still no retry", {31'h0, rt}, 32'h0);

    // R10: local bank hidden from PCI
    cfg_acc(1'b0, 7'd64, '0, rd, rt);
    chk("R10 bank read zero", rd, 32'h0);
    cfg_acc(1'b1, 7'd64, 32'h5555_0000, rd, rt);
    cfg_acc(1'b1, 7'd68, 32'h1, rd, rt);
    cfg_acc(1'b0, 7'd3, '0, rd, rt);
    chk("R11 unoccupied reads zero", rd, 32'h0);

    lcl_wr(7'd65, 32'h000F_FFFF);
    lcl_wr(7'd66, 32'h2000_0000);
    lcl_wr(7'd67, 32'h0000_FFFF);

    // R8: BAR low bits read zero
    cfg_acc(1'b1, 7'd4, 32'h8012_3456, rd, rt);
    cfg_acc(1'b0, 7'd4, '0, rd, rt);
    chk("R8 BAR0 masked", rd, 32'h8010_0000);
    cfg_acc(1'b1, 7'd5, 32'h9000_1234, rd, rt);
    cfg_acc(1'b0, 7'd5, '0, rd, rt);
    chk("R8 BAR1 masked", rd, 32'h9000_0000);

    // R10: PCI write of enable at 68 ignored -> window 1 off
    cmd_on: begin
      mem_probe(32'h8010_0000, h, w, la, ig);
      chk("R3 ignore when mem disabled", {31'h0, ig}, 32'h1);
      cfg_acc(1'b1, 7'd1, 32'h0000_0002, rd, rt);
      cfg_acc(1'b0, 7'd1, '0, rd, rt);
      chk("R3 command readback", rd, 32'h2);
    end
    mem_probe(32'h9000_1234, h, w, la, ig);
    chk("R10 PCI enable write ignored", {31'h0, h}, 32'h0);
    chk("R5 win1 disabled ignore", {31'h0, ig}, 32'h1);

    lcl_wr(7'd68, 32'h1);

    // R4: vector table
    for (int i = 0; i < NV; i++) begin
      mem_probe(VECS[i].addr, h, w, la, ig);
      chk($sformatf("R4 vec%0d hit", i), {31'h0, h}, {31'h0, VECS[i].hit});
      chk($sformatf("R4 vec%0d ignore", i), {31'h0, ig}, {31'h0, ~VECS[i].hit});
      chk($sformatf("R4 vec%0d win", i), {31'h0, w}, {31'h0, VECS[i].win});
      chk($sformatf("R4 vec%0d laddr", i), la, VECS[i].laddr);
    end

    // R5: disabling window 1 again
    lcl_wr(7'd68, 32'h0);
    mem_probe(32'h9000_1234, h, w, la, ig);
    chk("R5 win1 off after clear", {31'h0, h}, 32'h0);
    lcl_wr(7'd68, 32'h1);

    // R6: overlap -> window 0
    cfg_acc(1'b1, 7'd5, 32'h8010_0000, rd, rt);
    mem_probe(32'h8010_0020, h, w, la, ig);
    chk("R6 overlap hit", {31'h0, h}, 32'h1);
    chk("R6 overlap picks win0", {31'h0, w}, 32'h0);
    chk("R6 overlap laddr", la, 32'h1000_0020);

    // R7: window 0 size 0 never hits
    lcl_wr(7'd65, 32'h0);
    mem_probe(32'h8010_0020, h, w, la, ig);
    chk("R7 size0 falls to win1", {31'h0, w}, 32'h1);
    chk("R7 win1 laddr", la, 32'h2000_0020);
    mem_probe(32'h8018_0000, h, w, la, ig);
    chk("R7 size0 no hit", {31'h0, h}, 32'h0);
    cfg_acc(1'b0, 7'd4, '0, rd, rt);
    chk("R7 BAR reads zero", rd, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule